// File: doc/BRIEF.md
# Programmable polling bus controller

This block shares one system bus among up to eight units without any per-unit grant wire. It broadcasts a unit address on a shared group of poll lines, and a `poll_valid` strobe qualifies that address. The addresses come from a small sequence table that software writes. A unit that recognises its own address and wants the bus raises the shared `bus_busy` line and keeps it high while it uses the bus. The controller counts the cycles in which busy is high. When the slot budget is used up, it pulses `poll_release`. It then withdraws the address, waits for busy to fall, and polls the next table entry. If no unit answers within two cycles, the controller moves on at once.

The sequence table, the pass length and the slot budget are held twice. Software writes a shadow copy. The controller copies that shadow into its working copy only at the moment the sequence wraps back to entry 0, so a pass that has already begun is never changed.

The state machine has five states:

| State | Meaning |
|---|---|
| ST_START | Entered after reset. Leaves for ST_PRESENT once busy is low. |
| ST_PRESENT | Shows the address. Moves to ST_OWNED on busy, or advances after two idle cycles. |
| ST_OWNED | Counts the cycles in which busy is high. Moves to ST_RELEASE when the count reaches the slot budget. |
| ST_RELEASE | Lasts one cycle and drives the strobe. Always moves to ST_DRAIN. |
| ST_DRAIN | Waits for busy to be low, then advances. |

An advance always lands in ST_PRESENT, either on the next table entry or on entry 0 when the sequence wraps.

Top module: `poll_bus_ctrl`

## Requirements
- R1: While reset is asserted, `poll_valid`, `poll_release` and `poll_addr` are all 0. After reset, every table entry k holds address k, the pass length is 8 and the slot budget is 4. The first address (entry 0) is shown in the first cycle after reset is released, provided busy is low.
- R2: While `poll_valid` is high, `poll_addr` equals the working table entry at the current position. Positions run 0, 1, ... up to length-1 and then wrap to 0. While `poll_valid` is low, `poll_addr` is 0.
- R3: If busy is not sampled high while an address is shown, that address stays valid for exactly 2 cycles. The next entry follows directly, with `poll_valid` kept high.
- R4: If busy is sampled high while an address is shown, the controller holds that address. `poll_release` rises after busy has been sampled high on slot-budget further clock edges.
- R5: While the bus is owned, a cycle with busy low does not count toward the slot budget.
- R6: `poll_release` is high for exactly one cycle, and `poll_valid` is low during it. `poll_valid` then stays low until busy is sampled low, and the next address appears in the following cycle.
- R7: A write strobes `cfg_we`. `cfg_sel` values 0 to 7 write table entry `cfg_sel` from `cfg_wdata[2:0]`. A value of 8 writes the pass length from `cfg_wdata`, accepted only for 1 to 8. A value of 9 writes the slot budget from `cfg_wdata`, accepted only for 1 to 255. Rejected values and other `cfg_sel` codes change nothing.
- R8: Accepted writes reach the working table, length and budget only when the sequence wraps to entry 0. A write in the same cycle as the wrap waits for the following wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration target select |
| cfg_wdata | input | 8 | Configuration write data |
| bus_busy | input | 1 | Shared busy line driven by the owning unit |
| poll_addr | output | 3 | Unit address on the poll lines |
| poll_valid | output | 1 | Qualifies `poll_addr` |
| poll_release | output | 1 | One-cycle strobe asking the owner to free the bus |

## Verification
The delicate coincidence is a software write that arrives on the same clock edge as the sequence wrap. In that cycle the shadow copy takes the new value while the working copy takes the old shadow contents. The bench uses its own prediction to find the edge on which an idle last entry times out, drives a table write on exactly that edge, and expects the next pass to start with the value entry 0 held before the write. Random write traffic during bus ownership and slot release also provokes the same overlap. A cycle-level prediction judges every cycle against the requirements, and an explicit count of busy cycles is checked at each release.

// File: rtl/poll_pkg.sv
package poll_pkg;

    typedef enum logic [2:0] {
        ST_START   = 3'd0,
        ST_PRESENT = 3'd1,
        ST_OWNED   = 3'd2,
        ST_RELEASE = 3'd3,
        ST_DRAIN   = 3'd4
    } poll_state_e;

endpackage

// File: rtl/poll_seq_regs.sv
module poll_seq_regs #(
    parameter int N_UNITS    = 8,
    parameter int AW         = 3,
    parameter int LEN_W      = 4,
    parameter int CNT_W      = 8,
    parameter int SEL_W      = 4,
    parameter int SLOT_RESET = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             commit,
    input  logic [AW-1:0]    rd_idx,
    output logic [AW-1:0]    rd_entry,
    output logic [LEN_W-1:0] cur_len,
    output logic [CNT_W-1:0] cur_slot
);
    localparam int SEL_LEN  = N_UNITS;
    localparam int SEL_SLOT = N_UNITS + 1;

    logic [N_UNITS*AW-1:0] work_flat;
    logic [LEN_W-1:0]      shd_len;
    logic [CNT_W-1:0]      shd_slot;
    logic                  len_ok;
    logic                  slot_ok;

    assign len_ok  = (wr_data != '0) && (wr_data <= CNT_W'(N_UNITS));
    assign slot_ok = (wr_data != '0);

    // one shadow/working pair per sequence entry
    for (genvar g = 0; g < N_UNITS; g++) begin : g_entry
        logic [AW-1:0] shd_q;
        logic [AW-1:0] work_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shd_q  <= AW'(g);
                work_q <= AW'(g);
            end else begin
                if (commit)
                    work_q <= shd_q;
                if (wr_en && (wr_sel == SEL_W'(g)))
                    shd_q <= wr_data[AW-1:0];
            end
        end

        assign work_flat[g*AW +: AW] = work_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_len  <= LEN_W'(N_UNITS);
            cur_len  <= LEN_W'(N_UNITS);
            shd_slot <= CNT_W'(SLOT_RESET);
            cur_slot <= CNT_W'(SLOT_RESET);
        end else begin
            if (commit) begin
                cur_len  <= shd_len;
                cur_slot <= shd_slot;
            end
            if (wr_en && (wr_sel == SEL_W'(SEL_LEN)) && len_ok)
                shd_len <= wr_data[LEN_W-1:0];
            if (wr_en && (wr_sel == SEL_W'(SEL_SLOT)) && slot_ok)
                shd_slot <= wr_data;
        end
    end

    assign rd_entry = work_flat[rd_idx*AW +: AW];

endmodule

// File: rtl/poll_seq_fsm.sv
module poll_seq_fsm
    import poll_pkg::*;
#(
    parameter int AW       = 3,
    parameter int LEN_W    = 4,
    parameter int CNT_W    = 8,
    parameter int WAIT_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_busy,
    input  logic [LEN_W-1:0] cur_len,
    input  logic [CNT_W-1:0] cur_slot,
    output logic [AW-1:0]    idx,
    output poll_state_e      state,
    output logic [CNT_W-1:0] slot_cnt,
    output logic             commit,
    output logic             poll_valid,
    output logic             poll_release
);
    localparam int WAIT_W = $clog2(WAIT_CYC + 1);

    poll_state_e      state_q, state_d;
    logic [AW-1:0]    idx_q, idx_d;
    logic [WAIT_W-1:0] wait_q, wait_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             advance;
    logic             at_last;

    assign at_last = ((LEN_W'(idx_q) + LEN_W'(1)) == cur_len);

    // next-state and transition logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        wait_d  = wait_q;
        cnt_d   = cnt_q;
        advance = 1'b0;
        unique case (state_q)
            ST_START: begin
                if (!bus_busy)
                    state_d = ST_PRESENT;
            end
            ST_PRESENT: begin
                if (bus_busy) begin
                    state_d = ST_OWNED;
                    cnt_d   = '0;
                end else if (wait_q == WAIT_W'(WAIT_CYC - 1)) begin
                    advance = 1'b1;
                end else begin
                    wait_d = wait_q + WAIT_W'(1);
                end
            end
            ST_OWNED: begin
                if (bus_busy) begin
                    if (cnt_q == (cur_slot - CNT_W'(1)))
                        state_d = ST_RELEASE;
                    else
                        cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_RELEASE: begin
                state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (!bus_busy)
                    advance = 1'b1;
            end
            default: begin
                state_d = ST_START;
            end
        endcase
        if (advance) begin
            state_d = ST_PRESENT;
            wait_d  = '0;
            idx_d   = at_last ? '0 : idx_q + AW'(1);
        end
    end

    assign commit = advance && at_last;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_START;
            idx_q   <= '0;
            wait_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            wait_q  <= wait_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs decoded from state
    always_comb begin
        poll_valid   = 1'b0;
        poll_release = 1'b0;
        unique case (state_q)
            ST_PRESENT, ST_OWNED: poll_valid   = 1'b1;
            ST_RELEASE:           poll_release = 1'b1;
            default: begin
                poll_valid   = 1'b0;
                poll_release = 1'b0;
            end
        endcase
    end

    assign idx      = idx_q;
    assign state    = state_q;
    assign slot_cnt = cnt_q;

endmodule

// File: rtl/poll_bus_ctrl.sv
module poll_bus_ctrl
    import poll_pkg::*;
#(
    parameter int N_UNITS    = 8,
    parameter int CNT_W      = 8,
    parameter int WAIT_CYC   = 2,
    parameter int SLOT_RESET = 4,
    localparam int AW        = $clog2(N_UNITS),
    localparam int LEN_W     = $clog2(N_UNITS + 1),
    localparam int SEL_W     = $clog2(N_UNITS + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic             bus_busy,
    output logic [AW-1:0]    poll_addr,
    output logic             poll_valid,
    output logic             poll_release
);
    logic [AW-1:0]    cur_idx;
    logic [AW-1:0]    rd_entry;
    logic [LEN_W-1:0] cur_len;
    logic [CNT_W-1:0] cur_slot;
    logic [CNT_W-1:0] slot_cnt;
    logic             commit;
    poll_state_e      fsm_state;

    poll_seq_regs #(
        .N_UNITS   (N_UNITS),
        .AW        (AW),
        .LEN_W     (LEN_W),
        .CNT_W     (CNT_W),
        .SEL_W     (SEL_W),
        .SLOT_RESET(SLOT_RESET)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_wdata),
        .commit  (commit),
        .rd_idx  (cur_idx),
        .rd_entry(rd_entry),
        .cur_len (cur_len),
        .cur_slot(cur_slot)
    );

    poll_seq_fsm #(
        .AW      (AW),
        .LEN_W   (LEN_W),
        .CNT_W   (CNT_W),
        .WAIT_CYC(WAIT_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_busy    (bus_busy),
        .cur_len     (cur_len),
        .cur_slot    (cur_slot),
        .idx         (cur_idx),
        .state       (fsm_state),
        .slot_cnt    (slot_cnt),
        .commit      (commit),
        .poll_valid  (poll_valid),
        .poll_release(poll_release)
    );

    assign poll_addr = poll_valid ? rd_entry : '0;

endmodule

// File: rtl/poll_bus_chk.sv
module poll_bus_chk
    import poll_pkg::*;
#(
    parameter int AW    = 3,
    parameter int LEN_W = 4,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_busy,
    input logic [AW-1:0]    poll_addr,
    input logic             poll_valid,
    input logic             poll_release,
    input logic             commit,
    input logic [LEN_W-1:0] cur_len,
    input logic [CNT_W-1:0] cur_slot,
    input poll_state_e      state,
    input logic [CNT_W-1:0] slot_cnt
);
    a_r2_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !poll_valid |-> (poll_addr == '0));

    a_r6_release_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        poll_release |=> !poll_release);

    a_r6_release_hides_addr: assert property (@(posedge clk) disable iff (!rst_n)
        poll_release |-> !poll_valid);

    a_r6_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!poll_valid && bus_busy) |=> !poll_valid);

    a_r4_release_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
        poll_release |-> $past(bus_busy));

    a_r4_count_in_budget: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OWNED) |-> (slot_cnt < cur_slot));

    a_r5_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_OWNED) && !bus_busy) |=> $stable(slot_cnt));

    a_r8_len_only_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(cur_len));

    a_r8_slot_only_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(cur_slot));

endmodule

bind poll_bus_ctrl poll_bus_chk #(
    .AW   (AW),
    .LEN_W(LEN_W),
    .CNT_W(CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_busy    (bus_busy),
    .poll_addr   (poll_addr),
    .poll_valid  (poll_valid),
    .poll_release(poll_release),
    .commit      (commit),
    .cur_len     (cur_len),
    .cur_slot    (cur_slot),
    .state       (fsm_state),
    .slot_cnt    (slot_cnt)
);

// File: tb/poll_bus_ctrl_bench.sv
`timescale 1ns/1ps
module poll_bus_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic       bus_busy = 1'b0;
    logic [2:0] poll_addr;
    logic       poll_valid;
    logic       poll_release;

    always #2 clk = ~clk;

    poll_bus_ctrl u_poll_bus_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .bus_busy    (bus_busy),
        .poll_addr   (poll_addr),
        .poll_valid  (poll_valid),
        .poll_release(poll_release)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    // cycle predictor built from the requirements
    // phases: 0 start, 1 shown, 2 owned, 3 release, 4 drain
    int m_st, m_idx, m_wait, m_cnt;
    int sh_tab[8];
    int ac_tab[8];
    int sh_len, ac_len, sh_slot, ac_slot;
    bit m_adv;

    function automatic bit len_ok(int v);
        return (v >= 1) && (v <= 8);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_idx = 0; m_wait = 0; m_cnt = 0;
            for (int i = 0; i < 8; i++) begin
                sh_tab[i] = i;
                ac_tab[i] = i;
            end
            sh_len = 8; ac_len = 8; sh_slot = 4; ac_slot = 4;
        end else begin
            m_adv = 0;
            case (m_st)
                0: if (!bus_busy) m_st = 1;
                1: begin
                    if (bus_busy) begin m_st = 2; m_cnt = 0; end
                    else if (m_wait == 1) m_adv = 1;
                    else m_wait = m_wait + 1;
                end
                2: if (bus_busy) begin
                    if (m_cnt + 1 == ac_slot) m_st = 3;
                    else m_cnt = m_cnt + 1;
                end
                3: m_st = 4;
                default: if (!bus_busy) m_adv = 1;
            endcase
            if (m_adv) begin
                m_st = 1; m_wait = 0;
                if (m_idx + 1 == ac_len) begin
                    m_idx = 0;
                    ac_tab = sh_tab;
                    ac_len = sh_len;
                    ac_slot = sh_slot;
                end else begin
                    m_idx = m_idx + 1;
                end
            end
            if (cfg_we) begin
                if (cfg_sel < 8) sh_tab[cfg_sel] = int'(cfg_wdata[2:0]);
                else if (cfg_sel == 8 && len_ok(int'(cfg_wdata))) sh_len = int'(cfg_wdata);
                else if (cfg_sel == 9 && cfg_wdata != 0) sh_slot = int'(cfg_wdata);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1;
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL R2 watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // unit-side model
    int       owner = -1;
    bit       relp = 0;
    int       drop_cnt = 0;
    int       hi_cnt = 0;
    bit       pause_en = 0;
    int       max_drop = 0;
    logic [7:0] req = '0;

    task automatic tick(string tag);
        bit ev, er;
        int ea;
        @(negedge clk);
        cfg_we = 1'b0;
        ev = (m_st == 1) || (m_st == 2);
        ea = ev ? ac_tab[m_idx] : 0;
        er = (m_st == 3);
        check(poll_valid == ev, tag, "poll_valid R2/R6", int'(poll_valid), int'(ev));
        check(int'(poll_addr) == ea, tag, "poll_addr R2", int'(poll_addr), ea);
        check(poll_release == er, tag, "poll_release R4/R6", int'(poll_release), int'(er));
        if (owner >= 0) begin
            if (poll_release && !relp) begin
                relp = 1;
                drop_cnt = $urandom_range(max_drop, 0);
                check(hi_cnt == ac_slot + 1, "R4", "busy-high cycles at release (R5 pauses excluded)",
                      hi_cnt, ac_slot + 1);
            end
            if (relp) begin
                if (drop_cnt == 0) begin
                    bus_busy = 1'b0; owner = -1; relp = 0;
                end else begin
                    drop_cnt = drop_cnt - 1;
                    bus_busy = 1'b1;
                end
            end else if (pause_en && ($urandom_range(7, 0) == 0)) begin
                bus_busy = 1'b0;
            end else begin
                bus_busy = 1'b1;
                hi_cnt = hi_cnt + 1;
            end
        end else if (poll_valid && req[poll_addr]) begin
            owner = int'(poll_addr);
            bus_busy = 1'b1;
            hi_cnt = 1;
        end else begin
            bus_busy = 1'b0;
        end
    endtask

    task automatic write_cfg(int sel, int data, string tag);
        tick(tag);
        cfg_we = 1'b1;
        cfg_sel = 4'(sel);
        cfg_wdata = 8'(data);
    endtask

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(poll_valid == 1'b0, "R1", "reset poll_valid", int'(poll_valid), 0);
        check(poll_release == 1'b0, "R1", "reset poll_release", int'(poll_release), 0);
        check(poll_addr == 3'd0, "R1", "reset poll_addr", int'(poll_addr), 0);
        rst_n = 1'b1;

        // R1 identity order, R3 two-cycle idle timeout
        for (int n = 0; n < 16; n++) begin
            tick("R1 identity");
            check(poll_valid && (int'(poll_addr) == n / 2), "R3", "idle entry address",
                  int'(poll_addr), n / 2);
        end

        // R4 slot budget with one requester
        req = 8'h04;
        repeat (60) tick("R4 slot");
        // R5 paused ownership
        pause_en = 1;
        req = 8'h91;
        repeat (120) tick("R5 pause");
        pause_en = 0;
        // R6 late busy drop
        max_drop = 3;
        req = 8'h5A;
        repeat (80) tick("R6 drain");
        max_drop = 0;
        req = '0;
        repeat (20) tick("R6 settle");

        // R7 rejected writes
        write_cfg(8, 0, "R7 reject");
        write_cfg(8, 9, "R7 reject");
        write_cfg(9, 0, "R7 reject");
        write_cfg(12, 3, "R7 reject");
        repeat (40) tick("R7 after reject");

        // R8 deferred table, length and budget
        write_cfg(0, 6, "R8 deferred");
        write_cfg(1, 1, "R8 deferred");
        write_cfg(2, 6, "R8 deferred");
        write_cfg(8, 3, "R8 deferred");
        write_cfg(9, 2, "R8 deferred");
        repeat (60) tick("R8 deferred");
        req = 8'h02;
        repeat (40) tick("R8 new budget");
        req = '0;
        repeat (10) tick("R8 settle");

        // R8 write landing on the wrap edge
        for (int k = 0; k < 100; k++) begin
            if (m_st == 1 && m_wait == 1 && m_idx + 1 == ac_len && !bus_busy) break;
            tick("R8 seek wrap");
        end
        cfg_we = 1'b1;
        cfg_sel = 4'd0;
        cfg_wdata = 8'd3;
        tick("R8 wrap write");
        check(poll_valid && poll_addr == 3'd6, "R8", "entry 0 after wrap-cycle write",
              int'(poll_addr), 6);
        repeat (40) tick("R8 wrap write");

        // constrained random traffic
        for (int c = 0; c < 3000; c++) begin
            if (c % 25 == 0) begin
                req = 8'($urandom);
                pause_en = $urandom_range(1, 0);
                max_drop = $urandom_range(2, 0);
            end
            if ($urandom_range(29, 0) == 0)
                write_cfg($urandom_range(11, 0), $urandom_range(12, 0), "R2 random");
            else
                tick("R2 random");
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule